// File: doc/BRIEF.md
# Sync-check breaker close permissive

This block decides the instant at which a breaker tying an islanded AC system to a live network may be told to close. On every evaluation strobe it looks at the measured phase difference, the slip frequency and the two voltage magnitudes. It looks at them only while a close request is held. It checks that the phase, voltage ratio and slip all lie inside their windows on that same strobe. A breaker needs a fixed time to close. The block therefore fires ahead of the zero crossing, by a lead angle that grows with slip and with the breaker closing time, so that the contacts meet close to zero degrees.

A short write port holds the setpoints: the phase limits, the slip limit, the closing time and the close pulse width. Writes that fall outside the safe ranges are dropped. Once the close pulse has gone out, the block waits for the breaker auxiliary contact or for a timeout. While the auxiliary contact reports closed, no close pulse is produced. A sudden phase step while armed aborts the attempt. A voltage mismatch that holds the close back also leaves a fault code on a port.

Top module: `syncCheckTop`

## Requirements
- R1: The phase difference (signed, 0.01 degree units) must lie between the minimum setpoint (cfgAddr 1, default -1500) and the maximum setpoint (cfgAddr 0, default +1500), both ends included.
- R2: The voltage condition holds when 100·busMag ≥ 95·gridMag and 100·busMag ≤ 105·gridMag, both ends included.
- R3: The magnitude of the slip (signed, 0.001 Hz units) must be strictly below the slip limit (cfgAddr 2, default 200). A write of a value above 500 leaves the limit unchanged.
- R4: The closing time register (cfgAddr 3, milliseconds, default 60) takes only writes from 50 to 120. The lead angle in 0.01 degree units is |slip|·ms·36/1000 (integer division), saturated at 18000.
- R5: The approach distance d is -phase when slip ≥ 0 and +phase when slip < 0. With step = max(1, |slip|·STROBE_US·36/10^6), the timing condition holds when lead - step < d ≤ lead.
- R6: A close pulse starts only from an evaluation strobe on which closeReq is high and the conditions of R1, R2, R3 and R5 all hold. No strobe taken without closeReq fires.
- R7: closePulse rises in the cycle after the qualifying strobe. It stays high for exactly the pulse width (cfgAddr 4, default 4). A write of 0 or of a value above 255 is ignored.
- R8: After the pulse, the block waits for breakerClosed or for WAIT_CYCLES clock cycles. Strobes during that wait produce no pulse. After a timeout, a held request re-arms the block.
- R9: While breakerClosed is high, no close pulse is produced, whatever the request and measurements. The block stays latched until breakerClosed falls.
- R10: While armed, a change of more than JUMP_LIM (wrap-aware over ±18000) between two consecutive armed strobes aborts the attempt with no pulse. It sets faultCode to 0x43.
- R11: While armed, a strobe without a phase jump that fails the voltage condition sets faultCode to 0x12. The block stays armed.
- R12: After reset, closePulse is low and faultCode is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evalStb | input | 1 | One-cycle evaluation strobe |
| phaseDiff | input | PH_W | Signed phase difference, 0.01 degree |
| slipFreq | input | PH_W | Signed slip frequency, 0.001 Hz |
| busMag | input | MAG_W | Bus voltage magnitude |
| gridMag | input | MAG_W | Grid voltage magnitude |
| closeReq | input | 1 | Close request level |
| breakerClosed | input | 1 | Breaker auxiliary contact, high when closed |
| cfgWe | input | 1 | Setpoint write enable |
| cfgAddr | input | 3 | Setpoint select |
| cfgData | input | PH_W | Setpoint write data |
| closePulse | output | 1 | Close command pulse |
| faultCode | output | 8 | Most recent fault code, 0x00 if none |

## Verification
The assertions assume the following about the inputs. evalStb is a single-cycle pulse. The measurements and closeReq are steady during the cycle in which it is high. The breaker auxiliary input is a plain level with no timing link to the close pulse. The bench changes every input only on the falling clock edge and raises the strobe for exactly one cycle. It keeps consecutive armed phase samples within the jump limit, except in the scenario that provokes the 0x43 abort. It ends each successful attempt by pulsing breakerClosed, so that every scenario starts from the idle state.

// File: rtl/syncChkPkg.sv
package syncChkPkg;
  localparam logic [7:0] FAULT_NONE = 8'h00;
  localparam logic [7:0] FAULT_JUMP = 8'h43;
  localparam logic [7:0] FAULT_VOLT = 8'h12;

  // control -> datapath strobes
  typedef struct packed {
    logic track;      // armed: keep phase history for jump detection
    logic loadPulse;  // load counter with pulse width
    logic loadWait;   // load counter with confirmation timeout
    logic countDown;  // decrement counter
  } ctrlCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic phaseOk;
    logic voltOk;
    logic slipOk;
    logic inBand;
    logic jump;
    logic cntZero;
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_PULSE, ST_WAIT, ST_LATCHED
  } syncState_t;
endpackage

// File: rtl/syncDatapath.sv
module syncDatapath
  import syncChkPkg::*;
#(
  parameter int PH_W        = 16,
  parameter int MAG_W       = 16,
  parameter int WAIT_CYCLES = 64,
  parameter int STROBE_US   = 2000,
  parameter int JUMP_LIM    = 500
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    evalStb,
  input  logic signed [PH_W-1:0]  phaseDiff,
  input  logic signed [PH_W-1:0]  slipFreq,
  input  logic [MAG_W-1:0]        busMag,
  input  logic [MAG_W-1:0]        gridMag,
  input  logic                    cfgWe,
  input  logic [2:0]              cfgAddr,
  input  logic [PH_W-1:0]         cfgData,
  input  ctrlCmd_t                cmd,
  output dpStat_t                 stat
);
  localparam int PROD_W = PH_W + 24;
  localparam int WIDE   = PROD_W + 1;
  localparam int VP_W   = MAG_W + 7;
  localparam int CNT_W  = ($clog2(WAIT_CYCLES) > 8) ? $clog2(WAIT_CYCLES) : 8;

  localparam logic signed [PH_W-1:0] PH_DEF_MAX = PH_W'(1500);
  localparam logic signed [PH_W-1:0] PH_DEF_MIN = -PH_DEF_MAX;
  localparam logic [PH_W-1:0] SLIP_DEF = PH_W'(200);
  localparam logic [PH_W-1:0] SLIP_CAP = PH_W'(500);
  localparam logic [PH_W-1:0] MS_LO    = PH_W'(50);
  localparam logic [PH_W-1:0] MS_HI    = PH_W'(120);
  localparam logic [PROD_W-1:0] ANG_SAT = PROD_W'(18000);
  localparam logic [PH_W:0] HALF_TURN = (PH_W+1)'(18000);
  localparam logic [PH_W:0] FULL_TURN = (PH_W+1)'(36000);
  localparam logic [PH_W:0] JUMP_W    = (PH_W+1)'(JUMP_LIM);

  // setpoint registers
  logic signed [PH_W-1:0] phaseMaxR, phaseMinR;
  logic [PH_W-1:0]        slipLimR;
  logic [7:0]             closeMsR, pulseWR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseMaxR <= PH_DEF_MAX;
      phaseMinR <= PH_DEF_MIN;
      slipLimR  <= SLIP_DEF;
      closeMsR  <= 8'd60;
      pulseWR   <= 8'd4;
    end else if (cfgWe) begin
      case (cfgAddr)
        3'd0: phaseMaxR <= $signed(cfgData);
        3'd1: phaseMinR <= $signed(cfgData);
        3'd2: if (cfgData <= SLIP_CAP) slipLimR <= cfgData;
        3'd3: if (cfgData >= MS_LO && cfgData <= MS_HI) closeMsR <= cfgData[7:0];
        3'd4: if (cfgData[7:0] != 8'd0 && cfgData[PH_W-1:8] == '0) pulseWR <= cfgData[7:0];
        default: ;
      endcase
    end
  end

  // lead angle and per-strobe phase advance
  logic [PH_W-1:0]   absSlip;
  logic [PROD_W-1:0] leadRaw, leadSat, stepRaw, stepV;
  logic signed [WIDE-1:0] leadS, stepS, phaseW, distS;

  always_comb begin
    absSlip = slipFreq[PH_W-1] ? $unsigned(-slipFreq) : $unsigned(slipFreq);
    leadRaw = (PROD_W'(absSlip) * PROD_W'(closeMsR) * PROD_W'(36)) / PROD_W'(1000);
    leadSat = (leadRaw > ANG_SAT) ? ANG_SAT : leadRaw;
    stepRaw = (PROD_W'(absSlip) * PROD_W'(STROBE_US) * PROD_W'(36)) / PROD_W'(1000000);
    stepV   = (stepRaw == '0) ? PROD_W'(1) : stepRaw;
    leadS   = $signed({1'b0, leadSat});
    stepS   = $signed({1'b0, stepV});
    phaseW  = $signed({{(WIDE-PH_W){phaseDiff[PH_W-1]}}, phaseDiff});
    distS   = slipFreq[PH_W-1] ? phaseW : -phaseW;
  end

  // voltage ratio by cross multiplication
  logic [VP_W-1:0] busX100, gridX95, gridX105;
  always_comb begin
    busX100  = VP_W'(busMag)  * VP_W'(100);
    gridX95  = VP_W'(gridMag) * VP_W'(95);
    gridX105 = VP_W'(gridMag) * VP_W'(105);
  end

  // phase history for step detection
  logic signed [PH_W-1:0] prevPhase;
  logic                   prevValid;
  logic signed [PH_W:0]   deltaS;
  logic [PH_W:0]          absD, wrapD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPhase <= '0;
      prevValid <= 1'b0;
    end else if (!cmd.track) begin
      prevValid <= 1'b0;
    end else if (evalStb) begin
      prevPhase <= phaseDiff;
      prevValid <= 1'b1;
    end
  end

  always_comb begin
    deltaS = $signed({phaseDiff[PH_W-1], phaseDiff}) - $signed({prevPhase[PH_W-1], prevPhase});
    absD   = deltaS[PH_W] ? $unsigned(-deltaS) : $unsigned(deltaS);
    wrapD  = (absD > HALF_TURN) ? (FULL_TURN - absD) : absD;
  end

  // shared pulse / timeout counter
  logic [CNT_W-1:0] cntR;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cntR <= '0;
    else if (cmd.loadPulse)     cntR <= CNT_W'(pulseWR) - CNT_W'(1);
    else if (cmd.loadWait)      cntR <= CNT_W'(WAIT_CYCLES - 1);
    else if (cmd.countDown && cntR != '0) cntR <= cntR - CNT_W'(1);
  end

  always_comb begin
    stat.phaseOk = (phaseDiff >= phaseMinR) && (phaseDiff <= phaseMaxR);
    stat.voltOk  = (busX100 >= gridX95) && (busX100 <= gridX105);
    stat.slipOk  = absSlip < slipLimR;
    stat.inBand  = (distS <= leadS) && (distS > (leadS - stepS));
    stat.jump    = prevValid && (wrapD > JUMP_W);
    stat.cntZero = (cntR == '0);
  end
endmodule

// File: rtl/syncControl.sv
module syncControl
  import syncChkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evalStb,
  input  logic       closeReq,
  input  logic       breakerClosed,
  input  dpStat_t    stat,
  output ctrlCmd_t   cmd,
  output logic       closePulse,
  output logic       isArmed,
  output logic [7:0] faultCode
);
  syncState_t state;
  logic fireNow;

  always_comb begin
    fireNow = evalStb && stat.phaseOk && stat.voltOk && stat.slipOk
              && stat.inBand && !stat.jump;
    cmd.track     = (state == ST_ARMED);
    cmd.loadPulse = (state == ST_ARMED) && !breakerClosed && closeReq && fireNow;
    cmd.loadWait  = (state == ST_PULSE) && !breakerClosed && stat.cntZero;
    cmd.countDown = (state == ST_PULSE) || (state == ST_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      faultCode <= FAULT_NONE;
    end else begin
      case (state)
        ST_IDLE:
          if (breakerClosed) state <= ST_LATCHED;
          else if (closeReq) state <= ST_ARMED;
        ST_ARMED:
          if (breakerClosed)  state <= ST_LATCHED;
          else if (!closeReq) state <= ST_IDLE;
          else if (evalStb) begin
            if (stat.jump) begin
              faultCode <= FAULT_JUMP;
              state     <= ST_IDLE;
            end else if (!stat.voltOk) begin
              faultCode <= FAULT_VOLT;
            end else if (fireNow) begin
              state <= ST_PULSE;
            end
          end
        ST_PULSE:
          if (breakerClosed)     state <= ST_LATCHED;
          else if (stat.cntZero) state <= ST_WAIT;
        ST_WAIT:
          if (breakerClosed)     state <= ST_LATCHED;
          else if (stat.cntZero) state <= ST_IDLE;
        ST_LATCHED:
          if (!breakerClosed) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign closePulse = (state == ST_PULSE);
  assign isArmed    = (state == ST_ARMED);
endmodule

// File: rtl/syncCheckTop.sv
module syncCheckTop
  import syncChkPkg::*;
#(
  parameter int PH_W        = 16,
  parameter int MAG_W       = 16,
  parameter int WAIT_CYCLES = 64,
  parameter int STROBE_US   = 2000,
  parameter int JUMP_LIM    = 500
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   evalStb,
  input  logic signed [PH_W-1:0] phaseDiff,
  input  logic signed [PH_W-1:0] slipFreq,
  input  logic [MAG_W-1:0]       busMag,
  input  logic [MAG_W-1:0]       gridMag,
  input  logic                   closeReq,
  input  logic                   breakerClosed,
  input  logic                   cfgWe,
  input  logic [2:0]             cfgAddr,
  input  logic [PH_W-1:0]        cfgData,
  output logic                   closePulse,
  output logic [7:0]             faultCode
);
  ctrlCmd_t ctrlCmd;
  dpStat_t  dpStat;
  logic     ctrlArmed;

  syncDatapath #(
    .PH_W(PH_W), .MAG_W(MAG_W), .WAIT_CYCLES(WAIT_CYCLES),
    .STROBE_US(STROBE_US), .JUMP_LIM(JUMP_LIM)
  ) uDp (
    .clk(clk), .rstN(rstN), .evalStb(evalStb),
    .phaseDiff(phaseDiff), .slipFreq(slipFreq),
    .busMag(busMag), .gridMag(gridMag),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .cmd(ctrlCmd), .stat(dpStat)
  );

  syncControl uCtrl (
    .clk(clk), .rstN(rstN), .evalStb(evalStb),
    .closeReq(closeReq), .breakerClosed(breakerClosed),
    .stat(dpStat), .cmd(ctrlCmd),
    .closePulse(closePulse), .isArmed(ctrlArmed), .faultCode(faultCode)
  );
endmodule

// File: rtl/syncCheckAsserts.sv
module syncCheckAsserts
  import syncChkPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       evalStb,
  input logic       closeReq,
  input logic       breakerClosed,
  input logic       closePulse,
  input logic [7:0] faultCode,
  input logic       isArmed,
  input dpStat_t    stat
);
  // R6: a pulse starts only after a strobe with every window met and a request
  p_windows_met_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(closePulse) |-> $past(evalStb && closeReq && stat.phaseOk && stat.voltOk
                                && stat.slipOk && stat.inBand));

  // R9: a closed breaker seen on an edge leaves no pulse after it
  p_no_pulse_closed_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(breakerClosed) |-> !closePulse);

  // R10: phase step while armed aborts with code 0x43
  p_jump_fault_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(isArmed && closeReq && !breakerClosed && evalStb && stat.jump)
      |-> (faultCode == 8'h43) && !closePulse);

  // R11: voltage mismatch while armed reports code 0x12
  p_volt_fault_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(isArmed && closeReq && !breakerClosed && evalStb && !stat.jump && !stat.voltOk)
      |-> (faultCode == 8'h12) && !closePulse);
endmodule

bind syncCheckTop syncCheckAsserts uChk (
  .clk(clk), .rstN(rstN), .evalStb(evalStb), .closeReq(closeReq),
  .breakerClosed(breakerClosed), .closePulse(closePulse),
  .faultCode(faultCode), .isArmed(ctrlArmed), .stat(dpStat)
);

// File: tb/tb_syncCheckTop.sv
module tb_syncCheckTop;
  logic clk = 1'b0;
  logic rstN;
  logic evalStb;
  logic signed [15:0] phaseDiff, slipFreq;
  logic [15:0] busMag, gridMag;
  logic closeReq, breakerClosed, cfgWe;
  logic [2:0] cfgAddr;
  logic [15:0] cfgData;
  logic closePulse;
  logic [7:0] faultCode;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  syncCheckTop dut (
    .clk(clk), .rstN(rstN), .evalStb(evalStb), .phaseDiff(phaseDiff),
    .slipFreq(slipFreq), .busMag(busMag), .gridMag(gridMag),
    .closeReq(closeReq), .breakerClosed(breakerClosed), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .closePulse(closePulse),
    .faultCode(faultCode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrCfg(input int a, input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 3'(a); cfgData = 16'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic evalOnce(input int ph, input int sl, input int bus, input int grid);
    @(negedge clk);
    phaseDiff = 16'(ph); slipFreq = 16'(sl);
    busMag = 16'(bus); gridMag = 16'(grid);
    evalStb = 1'b1;
    @(negedge clk);
    evalStb = 1'b0;
  endtask

  task automatic measurePulse(output int n);
    n = 0;
    while (closePulse && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic arm();
    closeReq = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic releaseBreaker();
    closeReq = 1'b0; breakerClosed = 1'b1;
    repeat (2) @(negedge clk);
    breakerClosed = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // slip 150, 60 ms: lead 324, step 10, fire for d in (314,324]
  task automatic tReset();
    chk("R12 closePulse after reset", int'(closePulse), 0);
    chk("R12 faultCode after reset", int'(faultCode), 0);
  endtask

  task automatic tBasic();
    int n;
    arm();
    evalOnce(-330, 150, 1000, 1000);
    chk("R5 early, d=330", int'(closePulse), 0);
    evalOnce(-320, 150, 1000, 1000);
    chk("R5 in band fires", int'(closePulse), 1);
    measurePulse(n);
    chk("R7 default width 4", n, 4);
    releaseBreaker();
    arm();
    evalOnce(-310, 150, 1000, 1000);
    chk("R5 late, d=310", int'(closePulse), 0);
    releaseBreaker();
    arm();
    evalOnce(320, -150, 1000, 1000);
    chk("R5 negative slip fires at +320", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
  endtask

  task automatic tNoRequest();
    closeReq = 1'b0;
    repeat (2) @(negedge clk);
    evalOnce(-320, 150, 1000, 1000);
    chk("R6 no pulse without request", int'(closePulse), 0);
  endtask

  task automatic tVoltage();
    int n;
    arm();
    evalOnce(-320, 150, 1000, 1100);
    chk("R2 low ratio blocks", int'(closePulse), 0);
    chk("R11 fault 0x12", int'(faultCode), 8'h12);
    evalOnce(-320, 150, 950, 1000);
    chk("R2 ratio 0.95 accepted", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
    arm();
    evalOnce(-320, 150, 1051, 1000);
    chk("R2 ratio above 1.05 blocks", int'(closePulse), 0);
    evalOnce(-320, 150, 1050, 1000);
    chk("R2 ratio 1.05 accepted", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
  endtask

  task automatic tSlip();
    int n;
    arm();
    evalOnce(-425, 200, 1000, 1000);
    chk("R3 slip equal to limit blocks", int'(closePulse), 0);
    wrCfg(2, 600);
    evalOnce(-530, 250, 1000, 1000);
    chk("R3 write of 600 rejected", int'(closePulse), 0);
    wrCfg(2, 300);
    evalOnce(-530, 250, 1000, 1000);
    chk("R3 raised limit admits slip 250", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
    wrCfg(2, 200);
  endtask

  task automatic tCloseTime();
    int n;
    wrCfg(3, 100);
    arm();
    evalOnce(-535, 150, 1000, 1000);
    chk("R4 100 ms lead 540 fires", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
    wrCfg(3, 130);
    wrCfg(3, 40);
    arm();
    evalOnce(-535, 150, 1000, 1000);
    chk("R4 out-of-range writes ignored", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
    wrCfg(3, 60);
    arm();
    evalOnce(-535, 150, 1000, 1000);
    chk("R4 back to 60 ms, no fire", int'(closePulse), 0);
    releaseBreaker();
  endtask

  task automatic tPhaseWindow();
    int n;
    wrCfg(1, -300);
    arm();
    evalOnce(-320, 150, 1000, 1000);
    chk("R1 below min blocks", int'(closePulse), 0);
    wrCfg(1, -320);
    evalOnce(-320, 150, 1000, 1000);
    chk("R1 min inclusive", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
    wrCfg(1, -1500);
  endtask

  task automatic tPulseWidth();
    int n;
    wrCfg(4, 0);
    arm();
    evalOnce(-320, 150, 1000, 1000);
    measurePulse(n);
    chk("R7 zero width rejected", n, 4);
    releaseBreaker();
    wrCfg(4, 1);
    arm();
    evalOnce(-320, 150, 1000, 1000);
    measurePulse(n);
    chk("R7 width 1", n, 1);
    releaseBreaker();
    wrCfg(4, 4);
  endtask

  task automatic tWaitTimeout();
    int n;
    arm();
    evalOnce(-320, 150, 1000, 1000);
    measurePulse(n);
    evalOnce(-320, 150, 1000, 1000);
    chk("R8 no pulse during wait", int'(closePulse), 0);
    repeat (70) @(negedge clk);
    evalOnce(-320, 150, 1000, 1000);
    chk("R8 re-arms after timeout", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
  endtask

  task automatic tLatched();
    int n;
    breakerClosed = 1'b1; closeReq = 1'b1;
    repeat (2) @(negedge clk);
    evalOnce(-320, 150, 1000, 1000);
    chk("R9 closed breaker blocks", int'(closePulse), 0);
    evalOnce(-320, 150, 1000, 1000);
    chk("R9 repeated request ignored", int'(closePulse), 0);
    breakerClosed = 1'b0; closeReq = 1'b0;
    repeat (2) @(negedge clk);
    arm();
    evalOnce(-320, 150, 1000, 1000);
    measurePulse(n);
    breakerClosed = 1'b1;
    repeat (2) @(negedge clk);
    evalOnce(-320, 150, 1000, 1000);
    chk("R9 no pulse once confirmed", int'(closePulse), 0);
    releaseBreaker();
  endtask

  task automatic tJump();
    int n;
    arm();
    evalOnce(-900, 150, 1000, 1000);
    evalOnce(-320, 150, 1000, 1000);
    chk("R10 step of 580 aborts", int'(closePulse), 0);
    chk("R10 fault 0x43", int'(faultCode), 8'h43);
    @(negedge clk);
    evalOnce(-320, 150, 1000, 1000);
    chk("R10 fresh arm fires", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
    arm();
    evalOnce(-800, 150, 1000, 1000);
    evalOnce(-320, 150, 1000, 1000);
    chk("R10 step of 480 tolerated", int'(closePulse), 1);
    measurePulse(n);
    releaseBreaker();
  endtask

  initial begin
    rstN = 1'b0; evalStb = 1'b0; phaseDiff = '0; slipFreq = '0;
    busMag = 16'd1000; gridMag = 16'd1000; closeReq = 1'b0;
    breakerClosed = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tNoRequest();
    tVoltage();
    tSlip();
    tCloseTime();
    tPhaseWindow();
    tPulseWidth();
    tWaitTimeout();
    tLatched();
    tJump();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule